// File: doc/BRIEF.md
# Pixel Clock PLL Divider Solver

This block turns a requested pixel frequency, given in kHz, into the three integer settings of a PLL fed by a 14318 kHz reference: a feedback count N, a reference count M and a power-of-two post-divider exponent P. The synthesized frequency is N × 14318 / (M × 2^P). The block first tries a short priority list of standard frequencies, each with a tolerance window and fixed settings. When nothing in the list matches, it picks P from frequency bands. It then computes a ratio with 10 fractional bits and derives N and M from that ratio by rounding or by a downward search.

A request is a single-cycle `start` pulse carrying `freq_khz`. The block raises `busy` while it works and pulses `done` when the settings and the achieved frequency are on its outputs. It flags `err` when the request lies outside what the PLL can reach. Every integer division is done by one shared multi-cycle restoring divider, so the time to a result depends on the path taken.

Top module: `pll_pix_solver`

## Requirements
- R1: After reset, busy, done and err are 0, and n_out, m_out, p_out and f_out are all 0.
- R2: The standard list is checked in this priority order, with inclusive bounds, and the first window that holds the request supplies (M, N, P): 24923–25427 → (1,14,3); 31185–31815 → (3,53,3); 39600–40400 → (5,56,2); 49005–49995 → (6,83,2); 49500–50500 → (1,14,2); 64350–65650 → (9,82,1); 74250–75750 → (2,21,1).
- R3: Without a list match, P is 3 when f < 28636, 2 when f < 57272, 1 when f < 85908, and 0 otherwise.
- R4: Without a list match, r = floor(1024·f·2^P / 14318). If r > 261120 or r < 56, the result has err = 1, n_out = m_out = f_out = 0 and p_out set to the band value from R3.
- R5: When r is exactly 1024, N = M = 18.
- R6: When r > 1024, N is tried from 255 downward. For each N, M = floor(floor((2048·N + 1024)/r)/2). The first N whose M is at most 18 is kept, together with that M.
- R7: When r < 1024, M = 18 and N = floor((18·r + 512)/1024).
- R8: On a result without error, f_out = floor(N·14318 / (M·2^P)).
- R9: A start while busy is low is accepted, and busy is high from the next cycle. done is a one-cycle pulse during which busy is still high. A start while busy is high is ignored.
- R10: Between a done pulse and the end of the next accepted request, n_out, m_out, p_out, f_out and err hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse |
| freq_khz | input | FREQ_W | Requested pixel frequency in kHz |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result pulse |
| err | output | 1 | Request out of range |
| n_out | output | 8 | Feedback count N |
| m_out | output | 5 | Reference count M |
| p_out | output | 2 | Post-divider exponent P |
| f_out | output | FREQ_W | Achieved frequency in kHz |

## Verification
The bench aims at the edges of the decision tree. It uses requests one kHz either side of a list window and a request that falls into the two overlapping windows, where a wrong priority yields different settings. It uses frequencies on each side of the band thresholds, where an off-by-one comparison shifts P. It uses the exact ratio of 1.0, the lowest ratio that is accepted, and requests just inside and just outside both ratio limits, where a wrong comparison either rejects a reachable frequency or returns zero or overflowing divisors. A long search with a second start pulsed into its middle shows whether the running request is disturbed, and a quiet period after done shows whether the outputs drift or a ghost request runs.

// File: rtl/pll_pix_pkg.sv
package pll_pix_pkg;

    localparam int REF_KHZ = 14318;
    localparam int M_MAX   = 18;
    localparam int N_TOP   = 255;
    localparam int FRAC    = 10;
    localparam int STD_CNT = 7;
    localparam int N_W     = $clog2(N_TOP + 1);
    localparam int M_W     = $clog2(M_MAX + 1);

    typedef struct packed {
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
        logic [1:0]     p;
    } pll_set_t;

    typedef struct packed {
        logic [31:0] lo;
        logic [31:0] hi;
        pll_set_t    set;
    } std_ent_t;

    // Priority order matters: the earliest window that holds the request wins.
    localparam std_ent_t STD_TAB [STD_CNT] = '{
        '{lo: 32'd24923, hi: 32'd25427, set: '{n: 8'd14, m: 5'd1, p: 2'd3}},
        '{lo: 32'd31185, hi: 32'd31815, set: '{n: 8'd53, m: 5'd3, p: 2'd3}},
        '{lo: 32'd39600, hi: 32'd40400, set: '{n: 8'd56, m: 5'd5, p: 2'd2}},
        '{lo: 32'd49005, hi: 32'd49995, set: '{n: 8'd83, m: 5'd6, p: 2'd2}},
        '{lo: 32'd49500, hi: 32'd50500, set: '{n: 8'd14, m: 5'd1, p: 2'd2}},
        '{lo: 32'd64350, hi: 32'd65650, set: '{n: 8'd82, m: 5'd9, p: 2'd1}},
        '{lo: 32'd74250, hi: 32'd75750, set: '{n: 8'd21, m: 5'd2, p: 2'd1}}
    };

    typedef enum logic [2:0] {
        S_IDLE, S_LOOK, S_RATIO, S_SRCH, S_FREQ, S_FIN
    } solve_st_e;

    // Post-divider exponent chosen from the frequency band.
    function automatic logic [1:0] band_post(input logic [31:0] f);
        if (f < 32'(2 * REF_KHZ))      return 2'd3;
        else if (f < 32'(4 * REF_KHZ)) return 2'd2;
        else if (f < 32'(6 * REF_KHZ)) return 2'd1;
        else                           return 2'd0;
    endfunction

endpackage

// File: rtl/pll_std_table.sv
module pll_std_table
    import pll_pix_pkg::*;
#(
    parameter int FREQ_W = 22
) (
    input  logic [FREQ_W-1:0] freq,
    output logic              hit,
    output pll_set_t          set
);

    logic [31:0]        f32;
    logic [STD_CNT-1:0] in_win;

    assign f32 = 32'(freq);

    generate
        for (genvar gi = 0; gi < STD_CNT; gi++) begin : g_win
            assign in_win[gi] = (f32 >= STD_TAB[gi].lo) && (f32 <= STD_TAB[gi].hi);
        end
    endgenerate

    always_comb begin
        hit = |in_win;
        set = '0;
        // Walk from last to first so the earliest matching entry is the one kept.
        for (int i = STD_CNT - 1; i >= 0; i--) begin
            if (in_win[i]) set = STD_TAB[i].set;
        end
    end

endmodule

// File: rtl/pll_div_restoring.sv
module pll_div_restoring #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         valid,
    output logic [W-1:0] quo
);

    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt;
    logic          act;
    logic [W:0]    trial;

    // The quotient register doubles as the dividend shift register.
    assign trial = {rem, quo[W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            quo   <= '0;
            den_q <= '0;
            cnt   <= '0;
            act   <= 1'b0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (go) begin
                quo   <= num;
                den_q <= den;
                rem   <= '0;
                cnt   <= CW'(W);
                act   <= 1'b1;
            end else if (act) begin
                if (trial >= {1'b0, den_q}) begin
                    rem <= W'(trial - {1'b0, den_q});
                    quo <= {quo[W-2:0], 1'b1};
                end else begin
                    rem <= trial[W-1:0];
                    quo <= {quo[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    act   <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pll_pix_solver.sv
module pll_pix_solver
    import pll_pix_pkg::*;
#(
    parameter int FREQ_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FREQ_W-1:0] freq_khz,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [N_W-1:0]    n_out,
    output logic [M_W-1:0]    m_out,
    output logic [1:0]        p_out,
    output logic [FREQ_W-1:0] f_out
);

    localparam int DIV_W = FREQ_W + FRAC + 4;
    localparam logic [DIV_W-1:0] R_ONE  = DIV_W'(1 << FRAC);
    localparam logic [DIV_W-1:0] R_HI   = DIV_W'(N_TOP << FRAC);
    localparam logic [DIV_W-1:0] R_LO   = DIV_W'((1 << FRAC) / M_MAX);
    localparam logic [DIV_W-1:0] R_HALF = DIV_W'(1 << (FRAC - 1));
    localparam logic [DIV_W-1:0] D_MMAX = DIV_W'(M_MAX);
    localparam logic [DIV_W-1:0] D_REF  = DIV_W'(REF_KHZ);

    solve_st_e         st;
    logic [FREQ_W-1:0] f_q;
    pll_set_t          cur;
    logic [DIV_W-1:0]  r_q;

    logic              div_go;
    logic [DIV_W-1:0]  div_num;
    logic [DIV_W-1:0]  div_den;
    logic              dv_valid;
    logic [DIV_W-1:0]  q;

    logic              tab_hit;
    pll_set_t          tab_set;
    logic [1:0]        pb;
    logic [DIV_W-1:0]  lo_n_full;
    logic [DIV_W-1:0]  m_try;
    logic [N_W-1:0]    n_dec;

    pll_std_table #(.FREQ_W(FREQ_W)) u_tab (
        .freq (f_q),
        .hit  (tab_hit),
        .set  (tab_set)
    );

    pll_div_restoring #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .go    (div_go),
        .num   (div_num),
        .den   (div_den),
        .valid (dv_valid),
        .quo   (q)
    );

    always_comb begin
        pb        = band_post(32'(f_q));
        lo_n_full = (q * D_MMAX + R_HALF) >> FRAC;
        m_try     = q >> 1;
        n_dec     = cur.n - 1'b1;
    end

    assign busy = (st != S_IDLE);
    assign done = (st == S_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            f_q     <= '0;
            cur     <= '0;
            r_q     <= '0;
            div_go  <= 1'b0;
            div_num <= '0;
            div_den <= '0;
            err     <= 1'b0;
            n_out   <= '0;
            m_out   <= '0;
            p_out   <= '0;
            f_out   <= '0;
        end else begin
            div_go <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    if (start) begin
                        f_q <= freq_khz;
                        st  <= S_LOOK;
                    end
                end
                S_LOOK: begin
                    div_go <= 1'b1;
                    if (tab_hit) begin
                        cur     <= tab_set;
                        div_num <= DIV_W'(tab_set.n) * D_REF;
                        div_den <= DIV_W'(tab_set.m) << tab_set.p;
                        st      <= S_FREQ;
                    end else begin
                        cur     <= '{n: '0, m: '0, p: pb};
                        div_num <= DIV_W'(f_q) << (FRAC + int'(pb));
                        div_den <= D_REF;
                        st      <= S_RATIO;
                    end
                end
                S_RATIO: begin
                    if (dv_valid) begin
                        r_q <= q;
                        if ((q > R_HI) || (q < R_LO)) begin
                            err   <= 1'b1;
                            n_out <= '0;
                            m_out <= '0;
                            p_out <= cur.p;
                            f_out <= '0;
                            st    <= S_FIN;
                        end else if (q == R_ONE) begin
                            cur.n   <= N_W'(M_MAX);
                            cur.m   <= M_W'(M_MAX);
                            div_go  <= 1'b1;
                            div_num <= D_MMAX * D_REF;
                            div_den <= D_MMAX << cur.p;
                            st      <= S_FREQ;
                        end else if (q < R_ONE) begin
                            cur.n   <= lo_n_full[N_W-1:0];
                            cur.m   <= M_W'(M_MAX);
                            div_go  <= 1'b1;
                            div_num <= DIV_W'(lo_n_full[N_W-1:0]) * D_REF;
                            div_den <= D_MMAX << cur.p;
                            st      <= S_FREQ;
                        end else begin
                            cur.n   <= N_W'(N_TOP);
                            div_go  <= 1'b1;
                            div_num <= (DIV_W'(N_TOP) << (FRAC + 1)) | R_ONE;
                            div_den <= q;
                            st      <= S_SRCH;
                        end
                    end
                end
                S_SRCH: begin
                    if (dv_valid) begin
                        div_go <= 1'b1;
                        if (m_try <= D_MMAX) begin
                            cur.m   <= m_try[M_W-1:0];
                            div_num <= DIV_W'(cur.n) * D_REF;
                            div_den <= DIV_W'(m_try[M_W-1:0]) << cur.p;
                            st      <= S_FREQ;
                        end else begin
                            cur.n   <= n_dec;
                            div_num <= (DIV_W'(n_dec) << (FRAC + 1)) | R_ONE;
                            div_den <= r_q;
                        end
                    end
                end
                S_FREQ: begin
                    if (dv_valid) begin
                        err   <= 1'b0;
                        n_out <= cur.n;
                        m_out <= cur.m;
                        p_out <= cur.p;
                        f_out <= q[FREQ_W-1:0];
                        st    <= S_FIN;
                    end
                end
                S_FIN: begin
                    st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pll_pix_solver_chk.sv
module pll_pix_solver_chk
    import pll_pix_pkg::*;
#(
    parameter int FREQ_W = 22
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [FREQ_W-1:0] freq_khz,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [N_W-1:0]    n_out,
    input logic [M_W-1:0]    m_out,
    input logic [1:0]        p_out,
    input logic [FREQ_W-1:0] f_out
);

    // R9: done lasts a single cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: done is raised only inside a busy request
    a_r9_done_in_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R9: an idle start is accepted
    a_r9_start_accept: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R10: results do not move while idle
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !busy |=> (busy || ($stable(n_out) && $stable(m_out) && $stable(p_out)
                            && $stable(f_out) && $stable(err))));

    // R4: a rejected request reports zero settings
    a_r4_err_zero: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (n_out == '0 && m_out == '0 && f_out == '0));

    // R6: an accepted result keeps M within its limit and N nonzero
    a_r6_m_limit: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> (m_out >= M_W'(1) && m_out <= M_W'(M_MAX) && n_out != '0));

    // R1: unused request data does not matter; inputs stay known after reset
    a_r1_known: assert property (@(posedge clk) disable iff (rst)
        !$isunknown({busy, done}));

endmodule

bind pll_pix_solver pll_pix_solver_chk #(.FREQ_W(FREQ_W)) u_chk (.*);

// File: tb/test_pll_pix_solver.sv
module test_pll_pix_solver;

    localparam int FREQ_W = 22;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [FREQ_W-1:0] freq_khz = '0;
    logic              busy, done, err;
    logic [7:0]        n_out;
    logic [4:0]        m_out;
    logic [1:0]        p_out;
    logic [FREQ_W-1:0] f_out;

    int checks = 0;
    int errors = 0;
    bit prev_done = 1'b0;

    always #2.5 clk = ~clk;

    pll_pix_solver #(.FREQ_W(FREQ_W)) i_pll_pix_solver (
        .clk(clk), .rst(rst), .start(start), .freq_khz(freq_khz),
        .busy(busy), .done(done), .err(err),
        .n_out(n_out), .m_out(m_out), .p_out(p_out), .f_out(f_out)
    );

    // Every cycle: done must never last two cycles and must come with busy (R9).
    always @(negedge clk) begin
        if (!rst) begin
            if (done && prev_done) begin
                errors++;
                $display("FAIL R9 done held two cycles: actual 1 expected 0");
            end
            if (done && !busy) begin
                errors++;
                $display("FAIL R9 done without busy: actual busy=0 expected 1");
            end
        end
        prev_done = done;
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference of the requirements.
    function automatic void model(input longint f, output longint en, output longint em,
                                  output longint ep, output longint ef, output bit ee);
        longint lo[7];
        longint hi[7];
        longint tm[7];
        longint tn[7];
        longint tp[7];
        longint r;
        bit hit;
        lo = '{24923, 31185, 39600, 49005, 49500, 64350, 74250};
        hi = '{25427, 31815, 40400, 49995, 50500, 65650, 75750};
        tm = '{1, 3, 5, 6, 1, 9, 2};
        tn = '{14, 53, 56, 83, 14, 82, 21};
        tp = '{3, 3, 2, 2, 2, 1, 1};
        hit = 1'b0; ee = 1'b0; en = 0; em = 0; ep = 0; ef = 0;
        for (int i = 0; i < 7; i++) begin
            if (!hit && f >= lo[i] && f <= hi[i]) begin
                hit = 1'b1; en = tn[i]; em = tm[i]; ep = tp[i];
            end
        end
        if (!hit) begin
            if (f < 2*14318) ep = 3;
            else if (f < 4*14318) ep = 2;
            else if (f < 6*14318) ep = 1;
            else ep = 0;
            r = (1024 * f * (64'd1 << ep)) / 14318;
            if (r > 255*1024 || r < 1024/18) begin
                ee = 1'b1;
                return;
            end
            if (r == 1024) begin
                en = 18; em = 18;
            end else if (r > 1024) begin
                for (longint k = 255; k > 1; k--) begin
                    en = k;
                    em = ((k*2048 + 1024) / r) / 2;
                    if (em <= 18) break;
                end
            end else begin
                em = 18;
                en = (18*r + 512) / 1024;
            end
        end
        ef = (en * 14318) / (em * (64'd1 << ep));
    endfunction

    task automatic pulse_start(input longint f);
        @(negedge clk);
        freq_khz = FREQ_W'(f);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int cnt;
        cnt = 0;
        while (!done && cnt < 20000) begin
            @(negedge clk);
            cnt++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL %s watchdog: actual no done expected done", tag);
        end
    endtask

    task automatic compare(input string tag, input longint f);
        longint en, em, ep, ef;
        bit ee;
        model(f, en, em, ep, ef, ee);
        chk({tag, " err"}, err, ee);
        chk({tag, " N"}, n_out, en);
        chk({tag, " M"}, m_out, em);
        chk({tag, " P"}, p_out, ep);
        chk({tag, " f_out (R8)"}, f_out, ef);
    endtask

    task automatic run_case(input string tag, input longint f);
        pulse_start(f);
        chk({tag, " busy after start (R9)"}, busy, 1);
        wait_done(tag);
        compare(tag, f);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL global watchdog: actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 err", err, 0);
        chk("R1 N", n_out, 0);
        chk("R1 M", m_out, 0);
        chk("R1 P", p_out, 0);
        chk("R1 f_out", f_out, 0);

        // R2 list lookups, window edges, overlap priority
        run_case("R2 f=25175", 25175);
        run_case("R2 overlap f=49500", 49500);
        run_case("R2 upper edge f=50500", 50500);
        run_case("R2 upper edge f=75750", 75750);
        run_case("R2 below window f=24922", 24922);
        run_case("R2 lower edge f=64350", 64350);
        // R3 band thresholds
        run_case("R3 f=28635", 28635);
        run_case("R3 f=28636", 28636);
        run_case("R3 f=85907", 85907);
        run_case("R3 f=85908", 85908);
        // R5 exact unit ratio
        run_case("R5 f=1790", 1790);
        // R7 ratio below one
        run_case("R7 f=1000", 1000);
        run_case("R7 lowest ratio f=98", 98);
        // R4 limits
        run_case("R4 low reject f=97", 97);
        run_case("R4 top accepted f=3651090", 3651090);
        run_case("R4 high reject f=3651104", 3651104);
        // R6 search
        run_case("R6 f=100000", 100000);
        run_case("R6 f=14318", 14318);

        // R9: start while busy is ignored during a long search
        begin
            longint en, em, ep, ef;
            bit ee;
            logic [7:0] n_h;
            logic [FREQ_W-1:0] f_h;
            pulse_start(1800);
            repeat (3) @(negedge clk);
            freq_khz = FREQ_W'(25175);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            freq_khz = '0;
            wait_done("R6 R9 f=1800");
            compare("R6 R9 f=1800 with ignored start", 1800);
            model(1800, en, em, ep, ef, ee);
            n_h = n_out;
            f_h = f_out;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (done || busy) begin
                    errors++;
                    $display("FAIL R9 ghost request: actual busy=%0d done=%0d expected 0", busy, done);
                end
            end
            checks++;
            // R10 outputs held after done
            chk("R10 N held", n_out, n_h);
            chk("R10 f_out held", f_out, f_h);
            chk("R10 N value", n_out, en);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule